// File: doc/BRIEF.md
# Two-Level Page Walker

This block maps a 32-bit linear address to a physical address for a core running with paging switched on. A request carries the linear address, a read/write flag, a user/supervisor flag, the paging enable bit, the write-protect control bit and the directory base register. With paging off, the block returns the linear address unchanged and makes no memory access. With paging on, it reads one directory entry and then one table entry over a single 32-bit memory read port. It then checks the access against the combined permissions of both entries and returns a frame-plus-offset physical address or a page fault.

Each result is reported by a one-cycle `done` pulse. A fault also loads the offending linear address into a fault address register, which keeps that value until the next fault. Pages are 4 KB. Linear address bits 31..22 index the directory, bits 21..12 index the table, and bits 11..0 are the byte offset. The block takes a request only while `busy` is low.

Top module: `pgwalk_top`

## Requirements
- R1: A request taken with `pg_en` = 0 gives `done` = 1, `fault` = 0 and `phys_addr` equal to the request's linear address in the cycle after acceptance. No memory read is issued for it.
- R2: A translation that succeeds returns `phys_addr` = {table entry bits 31..12, linear address bits 11..0}.
- R3: The directory entry is read at {dir_base[31:12], 12'h000} + 4 × linear[31:22]. The table entry is then read at {directory entry[31:12], 12'h000} + 4 × linear[21:12].
- R4: In each entry, bit 0 is present, bit 1 is write-allowed and bit 2 is user-allowed. A directory entry with bit 0 clear ends the walk with `fault` = 1 and `fault_np` = 1 (not-present), and no table read is made.
- R5: A table entry with bit 0 clear ends the walk with `fault` = 1 and `fault_np` = 1.
- R6: A user access (`req_user` = 1) faults with `fault_np` = 0 unless bit 2 is set in both entries.
- R7: A user write faults with `fault_np` = 0 unless bit 1 is set in both entries.
- R8: A supervisor write to a page whose combined bit 1 is clear faults only when `wp_en` = 1. A supervisor read never gives a protection fault.
- R9: Every fault loads `fault_addr` with the faulting linear address. `fault_addr` keeps its value across successful results until the next fault.
- R10: `req_valid` is ignored while `busy` = 1. The result of the walk in progress is not affected.
- R11: The walk waits any number of cycles for `mem_ack` and holds `mem_rd` and `mem_addr` steady while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, taken when `busy` = 0 |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| pg_en | input | 1 | Paging enable |
| wp_en | input | 1 | Write-protect control for supervisor writes |
| dir_base | input | 32 | Directory base register; bits 31..12 are used |
| busy | output | 1 | A walk is in progress |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 32 | Address of the entry being read |
| mem_ack | input | 1 | Read data valid for the current request |
| mem_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle result pulse |
| fault | output | 1 | The result is a page fault |
| fault_np | output | 1 | With `fault`: 1 = not-present, 0 = protection |
| phys_addr | output | 32 | Translated address, valid with `done` and not `fault` |
| fault_addr | output | 32 | Linear address of the most recent fault |

## Verification
The assertions assume a well-behaved memory port. `mem_ack` rises only while `mem_rd` is high and lasts one cycle, and `mem_data` is valid in that same cycle. The bench's responder follows these rules. It answers only an outstanding read, drops the acknowledge after one cycle and returns the model memory's word for the address it sees. Paging enable, write-protect and the directory base are sampled when a request is taken. The bench changes them only between requests, and it drives `req_valid` during a walk only to exercise the ignore rule.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  parameter int DIR_W = 10;
  parameter int TBL_W = 10;
  parameter int OFF_W = 12;
  localparam int AW    = DIR_W + TBL_W + OFF_W;
  localparam int BIT_P  = 0;
  localparam int BIT_RW = 1;
  localparam int BIT_US = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_DIR, ST_TBL} wstate_e;

  // entry address: page-aligned base plus four bytes per index step
  function automatic logic [AW-1:0] entry_addr(input logic [AW-1:0] base,
                                               input logic [AW-1:0] idx);
    return {base[AW-1:OFF_W], {OFF_W{1'b0}}} + (idx << 2);
  endfunction

  function automatic logic [AW-1:0] phys_of(input logic [AW-1:0] pte,
                                            input logic [AW-1:0] lin);
    return {pte[AW-1:OFF_W], lin[OFF_W-1:0]};
  endfunction

  // the more restrictive of the two levels wins for both bits
  function automatic logic prot_fault(input logic [AW-1:0] pde,
                                      input logic [AW-1:0] pte,
                                      input logic user, input logic write,
                                      input logic wp);
    logic us_ok, rw_ok;
    us_ok = pde[BIT_US] & pte[BIT_US];
    rw_ok = pde[BIT_RW] & pte[BIT_RW];
    if (user) return !us_ok || (write && !rw_ok);
    return write && !rw_ok && wp;
  endfunction
endpackage

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
  import pgwalk_pkg::*;
(
  input  logic [AW-1:0] pde,
  input  logic [AW-1:0] pte,
  input  logic          user,
  input  logic          write,
  input  logic          wp,
  output logic          viol
);
  assign viol = prot_fault(pde, pte, user, write, wp);

  always_comb begin
    AST_SUP_READ_FREE: assert (user || write || !viol); // R8
  end
endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
  import pgwalk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_lin,
  input  logic          req_write,
  input  logic          req_user,
  input  logic          pg_en,
  input  logic          wp_en,
  input  logic [AW-1:0] dir_base,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_data,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic          busy,
  output logic [AW-1:0] lin_q,
  output logic [AW-1:0] pde_q,
  output logic          user_q,
  output logic          write_q,
  output logic          wp_q,
  output logic          ev_byp,
  output logic          ev_dir_np,
  output logic          ev_tbl_np,
  output logic          ev_tbl_hit
);
  wstate_e       st;
  logic [AW-1:0] base_q;
  logic          accept;

  assign accept = (st == ST_IDLE) && req_valid;
  assign busy   = (st != ST_IDLE);
  assign mem_rd = (st == ST_DIR) || (st == ST_TBL);

  // named walk events, consumed by the result registers in the top
  assign ev_byp     = accept && !pg_en;
  assign ev_dir_np  = (st == ST_DIR) && mem_ack && !mem_data[BIT_P];
  assign ev_tbl_np  = (st == ST_TBL) && mem_ack && !mem_data[BIT_P];
  assign ev_tbl_hit = (st == ST_TBL) && mem_ack &&  mem_data[BIT_P];

  always_comb begin
    case (st)
      ST_DIR:  mem_addr = entry_addr(base_q, AW'(lin_q[AW-1 -: DIR_W]));
      ST_TBL:  mem_addr = entry_addr(pde_q,  AW'(lin_q[OFF_W +: TBL_W]));
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      lin_q   <= '0;
      base_q  <= '0;
      pde_q   <= '0;
      user_q  <= 1'b0;
      write_q <= 1'b0;
      wp_q    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          lin_q   <= req_lin;
          base_q  <= dir_base;
          user_q  <= req_user;
          write_q <= req_write;
          wp_q    <= wp_en;
          if (pg_en) st <= ST_DIR;
        end
        ST_DIR: if (mem_ack) begin
          pde_q <= mem_data;
          st    <= mem_data[BIT_P] ? ST_TBL : ST_IDLE;
        end
        ST_TBL: if (mem_ack) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr))); // R11
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[1:0] == 2'b00)); // R3
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(lin_q)); // R10
  AST_NP_STOPS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dir_np |=> !mem_rd); // R4
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_lin,
  input  logic          req_write,
  input  logic          req_user,
  input  logic          pg_en,
  input  logic          wp_en,
  input  logic [AW-1:0] dir_base,
  output logic          busy,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_data,
  output logic          done,
  output logic          fault,
  output logic          fault_np,
  output logic [AW-1:0] phys_addr,
  output logic [AW-1:0] fault_addr
);
  logic [AW-1:0] lin_q, pde_q;
  logic          user_q, write_q, wp_q;
  logic          ev_byp, ev_dir_np, ev_tbl_np, ev_tbl_hit;
  logic          viol, walk_fault;

  pgwalk_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin(req_lin),
    .req_write(req_write), .req_user(req_user), .pg_en(pg_en),
    .wp_en(wp_en), .dir_base(dir_base), .mem_ack(mem_ack),
    .mem_data(mem_data), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .busy(busy), .lin_q(lin_q), .pde_q(pde_q), .user_q(user_q),
    .write_q(write_q), .wp_q(wp_q), .ev_byp(ev_byp),
    .ev_dir_np(ev_dir_np), .ev_tbl_np(ev_tbl_np), .ev_tbl_hit(ev_tbl_hit)
  );

  pgwalk_perm u_perm (
    .pde(pde_q), .pte(mem_data), .user(user_q), .write(write_q),
    .wp(wp_q), .viol(viol)
  );

  assign walk_fault = ev_dir_np || ev_tbl_np || (ev_tbl_hit && viol);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_np   <= 1'b0;
      phys_addr  <= '0;
      fault_addr <= '0;
    end else begin
      done     <= ev_byp || ev_dir_np || ev_tbl_np || ev_tbl_hit;
      fault    <= walk_fault;
      fault_np <= ev_dir_np || ev_tbl_np;
      if (ev_byp)                   phys_addr <= req_lin;
      else if (ev_tbl_hit && !viol) phys_addr <= phys_of(mem_data, lin_q);
      if (walk_fault)               fault_addr <= lin_q;
    end
  end

  AST_BYPASS_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !pg_en) |=>
      (done && !fault && phys_addr == $past(req_lin))); // R1
  AST_BYPASS_NOREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !pg_en) |=> !mem_rd); // R1
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (phys_addr[OFF_W-1:0] == lin_q[OFF_W-1:0])); // R2
  AST_FAULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (done && fault_addr == lin_q)); // R9
  AST_FADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> $stable(fault_addr)); // R9
  AST_NP_IS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_np |-> fault); // R5
endmodule

// File: tb/sim_pgwalk_top.sv
module sim_pgwalk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic        pg_en = 1'b0, wp_en = 1'b0;
  logic [31:0] req_lin = '0, dir_base = 32'h0010_0000;
  logic        busy, mem_rd, done, fault, fault_np;
  logic [31:0] mem_addr, phys_addr, fault_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_data = '0;

  int total = 0, bad = 0;
  int lat = 0, wcnt = 0, rd_cnt = 0;
  logic [31:0] ref_fa = '0;
  logic [31:0] mem [int];

  typedef struct {
    logic f; logic np; logic [31:0] pa; int nrd; string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  pgwalk_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin(req_lin),
    .req_write(req_write), .req_user(req_user), .pg_en(pg_en),
    .wp_en(wp_en), .dir_base(dir_base), .busy(busy), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
    .done(done), .fault(fault), .fault_np(fault_np),
    .phys_addr(phys_addr), .fault_addr(fault_addr)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // memory responder: answers an outstanding read after lat idle cycles
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_rd) begin
      if (wcnt >= lat) begin
        mem_data = rd(mem_addr);
        mem_ack = 1'b1;
        rd_cnt++;
      end else wcnt++;
    end
  end

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (q.size() == 0) chk(0, "R10 unexpected done", 32'h1, 32'h0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(fault == e.f, {e.tag, " fault"}, 32'(fault), 32'(e.f));
          if (e.f) chk(fault_np == e.np, {e.tag, " fault kind"}, 32'(fault_np), 32'(e.np));
          else     chk(phys_addr == e.pa, {e.tag, " phys"}, phys_addr, e.pa);
          chk(rd_cnt == e.nrd, {e.tag, " read count"}, 32'(rd_cnt), 32'(e.nrd));
          if (e.f) ref_fa = req_hold;
        end
      end
      chk(fault_addr == ref_fa, "R9 fault address", fault_addr, ref_fa);
    end
  end

  logic [31:0] req_hold = '0;

  function automatic exp_t model(input logic [31:0] lin, input bit wr,
                                 input bit usr, input bit pg, input bit wp);
    exp_t e;
    logic [31:0] d, t;
    bit ok_user, ok_wr, deny;
    e.f = 0; e.np = 0; e.pa = lin; e.nrd = 0; e.tag = "";
    if (!pg) return e;
    d = rd((dir_base & 32'hFFFF_F000) + ((lin >> 22) & 32'h3FF) * 4);
    e.nrd = 1;
    if (d % 2 == 0) begin e.f = 1; e.np = 1; return e; end
    t = rd((d & 32'hFFFF_F000) + ((lin >> 12) & 32'h3FF) * 4);
    e.nrd = 2;
    if (t % 2 == 0) begin e.f = 1; e.np = 1; return e; end
    ok_user = d[2] && t[2];
    ok_wr   = d[1] && t[1];
    if (usr) deny = !ok_user || (wr && !ok_wr);
    else     deny = wr && wp && !ok_wr;
    e.f = deny;
    e.pa = (t & 32'hFFFF_F000) | (lin & 32'h0000_0FFF);
    return e;
  endfunction

  function automatic logic [31:0] mk(input int dx, input int tx, input int off);
    return (32'(dx) << 22) | (32'(tx) << 12) | 32'(off);
  endfunction

  task automatic issue(input logic [31:0] lin, input bit wr, input bit usr,
                       input bit pg, input bit wp, input string tag,
                       input bit noise);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    e = model(lin, wr, usr, pg, wp);
    e.tag = tag;
    q.push_back(e);
    rd_cnt = 0;
    req_hold = lin;
    req_lin = lin; req_write = wr; req_user = usr; pg_en = pg; wp_en = wp;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!pg) chk(done == 1'b1, "R1 done next cycle", 32'(done), 32'h1);
    if (noise) begin
      // R10: requests while busy must be dropped
      req_lin = 32'hFFFF_FFFF; req_write = 1'b1; req_user = 1'b1;
      req_valid = 1'b1;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
    end
    do @(posedge clk); while (q.size() != 0);
  endtask

  initial begin
    // directory at 0x0010_0000; bit0 present, bit1 write, bit2 user
    mem[32'h0010_0004] = 32'h0020_0007;
    mem[32'h0010_0008] = 32'h0030_0005;
    mem[32'h0010_000C] = 32'h0040_0003;
    mem[32'h0010_0010] = 32'h0000_0000;
    mem[32'h0020_000C] = 32'h0ABC_D007;
    mem[32'h0020_0010] = 32'h0ABC_E005;
    mem[32'h0020_0014] = 32'h0ABC_F003;
    mem[32'h0020_0018] = 32'h0000_0006;
    mem[32'h0030_0000] = 32'h1234_5007;
    mem[32'h0040_0000] = 32'h2222_2007;
    mem[32'h0040_0FFC] = 32'h7777_7007;

    repeat (3) @(negedge clk);
    chk(done == 0 && fault == 0, "reset outputs", {30'h0, done, fault}, 32'h0);
    chk(mem_rd == 0 && busy == 0, "reset walk idle", {30'h0, mem_rd, busy}, 32'h0);
    rst_n = 1'b1;

    issue(32'hDEAD_BEEF, 0, 1, 0, 0, "R1 bypass", 0);
    issue(32'h0000_0001, 1, 0, 0, 1, "R1 bypass write", 0);
    issue(mk(1, 3, 12'h123), 0, 1, 1, 0, "R2 R3 user read", 0);
    issue(mk(1, 3, 12'hFFF), 1, 1, 1, 1, "R2 user write", 0);
    issue(mk(1, 4, 12'h010), 0, 1, 1, 0, "R7 user read ro", 0);
    issue(mk(1, 4, 12'h010), 1, 1, 1, 0, "R7 user write ro", 0);
    issue(mk(1, 5, 12'h020), 0, 1, 1, 0, "R6 user on sup page", 0);
    issue(mk(1, 5, 12'h020), 1, 0, 1, 1, "R6 sup write", 0);
    issue(mk(1, 6, 12'h030), 0, 0, 1, 0, "R5 table not present", 0);
    issue(mk(1, 3, 12'h040), 0, 0, 1, 0, "R9 hold after ok", 0);
    issue(mk(4, 0, 12'h050), 0, 0, 1, 0, "R4 dir not present", 0);
    issue(mk(2, 0, 12'h060), 1, 1, 1, 0, "R7 dir ro user write", 0);
    issue(mk(2, 0, 12'h070), 1, 0, 1, 1, "R8 sup write wp on", 0);
    issue(mk(2, 0, 12'h080), 1, 0, 1, 0, "R8 sup write wp off", 0);
    issue(mk(2, 0, 12'h090), 0, 0, 1, 1, "R8 sup read", 0);
    issue(mk(3, 0, 12'h0A0), 0, 1, 1, 0, "R6 dir sup user read", 0);
    issue(mk(3, 1023, 12'h0B0), 1, 0, 1, 1, "R3 last table slot", 0);
    lat = 1;
    issue(mk(1, 3, 12'h0C0), 0, 1, 1, 0, "R11 latency 1", 0);
    lat = 3;
    issue(mk(1, 6, 12'h0D0), 0, 1, 1, 0, "R11 latency 3 fault", 0);
    issue(mk(1, 3, 12'h0E0), 0, 1, 1, 0, "R10 busy ignore", 1);
    lat = 0;
    issue(mk(1, 3, 12'h0F0), 0, 1, 1, 0, "R10 after ignore", 0);

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R10 no extra result", 32'(q.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule